// File: doc/BRIEF.md
# Pin Sense Detect Latch

This unit watches a port of already-synchronised input pins and turns the level on each of them into a single port-wide detect line, with a one-cycle event pulse for a downstream event controller. Each pin has a two-bit sense code. The code can switch sensing off, or arm the pin for a high level or a low level. The pins that currently match their code form the live detect vector.

A sticky latch register collects every pin that has matched since it was last cleared. Software clears it by writing ones, but a pin that still matches keeps its bit. A one-bit mode chooses what drives the detect line: the live vector or the latched vector. In latched mode, a clear that leaves bits behind pulls the detect line low for a parameterised number of cycles. The line then rises again, so the event controller sees a fresh edge for the pins that are still pending.

Top module: `pin_sense_detect`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `latch_o` is zero, `detect_o` and `event_o` are low and the detect mode is live. Every pin's sense code is 0, so no pin level sets a latch bit.
- R2: Sense code bit 1 enables a pin and bit 0 inverts it. Codes 0 and 1 never detect, code 2 detects a high pin and code 3 detects a low pin. The live bit of pin i is (pin_in[i] XOR code[0]) AND code[1].
- R3: A latch bit that is set stays set after its pin stops matching, unless a clear names it. On every clock edge the latch takes in the live vector.
- R4: A clear write (`clr_we`) clears the latch bits where `clr_mask` is 1 and leaves the bits where it is 0 unchanged.
- R5: A latch bit whose pin still matches at the clear edge stays set, even if `clr_mask` names it.
- R6: In live mode (mode value 0), `detect_o` goes high on the clock edge after the live vector becomes nonzero. It goes low on the edge after the live vector becomes zero.
- R7: In latched mode (mode value 1), `detect_o` is high exactly while the latch is nonzero. This holds even when no pin is matching any more.
- R8: `event_o` is high for one cycle, in the first cycle in which `detect_o` is high after being low. At no other time is it high.
- R9: In latched mode, a clear with a nonzero mask that leaves the latch nonzero holds `detect_o` low for HOLD_CYCLES cycles. The line then rises again and raises a new event.
- R10: A sense-code write or a mode write is applied at the same clock edge that stores it. The detect line and the event may change on that edge.
- R11: A clear with an all-zero mask never starts the low-hold. Neither does any clear in live mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NUM_PINS | Synchronised pin levels |
| cfg_we | input | 1 | Write strobe for one pin's sense code |
| cfg_pin | input | IDX_W | Index of the pin whose sense code is written |
| cfg_sense | input | 2 | New sense code (bit 1 enable, bit 0 invert) |
| mode_we | input | 1 | Write strobe for the detect mode |
| mode_val | input | 1 | New mode: 0 live, 1 latched |
| clr_we | input | 1 | Write-one-to-clear strobe for the latch |
| clr_mask | input | NUM_PINS | Latch bits to clear |
| latch_o | output | NUM_PINS | Latched detect vector |
| detect_o | output | 1 | Port detect line |
| event_o | output | 1 | One-cycle pulse on a rising edge of the detect line |

## Verification
The bench builds the block with NUM_PINS = 4 and HOLD_CYCLES = 3. This is small enough to sweep every pin against every sense code and both starting levels, and then the opposite level, with each pin tested alone. Three hold cycles make it possible to observe each cycle of the low-hold and the following re-raise. A directed sequence then covers clears that are blocked by pins still matching, in both modes. It also covers zero-mask clears and mode switches that raise an event on their own.

// File: rtl/psd_pkg.sv
package psd_pkg;

  typedef enum logic {
    MODE_LIVE    = 1'b0,
    MODE_LATCHED = 1'b1
  } det_mode_e;

  typedef struct packed {
    logic en;
    logic inv;
  } sense_cfg_t;

  function automatic sense_cfg_t decode_sense(input logic [1:0] code);
    sense_cfg_t c;
    c.en  = code[1];
    c.inv = code[0];
    return c;
  endfunction

endpackage

// File: rtl/psd_sense_cfg.sv
module psd_sense_cfg
  import psd_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_pin,
  input  logic [1:0]          cfg_sense,
  output logic [NUM_PINS-1:0] live_vec
);

  sense_cfg_t wr_cfg;
  assign wr_cfg = decode_sense(cfg_sense);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    sense_cfg_t cfg_q;
    sense_cfg_t cfg_eff;
    logic       hit;

    assign hit     = cfg_we && (cfg_pin == IDX_W'(i));
    assign cfg_eff = hit ? wr_cfg : cfg_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q <= '0;
      end else if (hit) begin
        cfg_q <= wr_cfg;
      end
    end

    assign live_vec[i] = cfg_eff.en & (pin_in[i] ^ cfg_eff.inv);
  end

endmodule

// File: rtl/psd_latch_vec.sv
module psd_latch_vec #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] live_vec,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] latch_q,
  output logic [NUM_PINS-1:0] latch_nxt,
  output logic                clr_fired
);

  logic [NUM_PINS-1:0] clr_eff;

  assign clr_eff   = clr_we ? clr_mask : '0;
  assign clr_fired = clr_we && (|clr_mask);
  assign latch_nxt = (latch_q & ~clr_eff) | live_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else begin
      latch_q <= latch_nxt;
    end
  end

endmodule

// File: rtl/psd_detect_gen.sv
module psd_detect_gen
  import psd_pkg::*;
#(
  parameter int HOLD_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic live_any,
  input  logic latch_any_nxt,
  input  logic clr_fired,
  input  logic mode_we,
  input  logic mode_val,
  output logic mode_q,
  output logic detect_o,
  output logic event_o
);

  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYCLES - 1);

  det_mode_e        mode_r;
  det_mode_e        mode_eff;
  logic [CNT_W-1:0] hold_cnt;
  logic             hold_start;
  logic             force_low;
  logic             sel_line;
  logic             det_nxt;

  assign mode_eff   = mode_we ? det_mode_e'(mode_val) : mode_r;
  assign hold_start = clr_fired && (mode_eff == MODE_LATCHED) && latch_any_nxt;
  assign force_low  = hold_start || (hold_cnt != '0);
  assign sel_line   = (mode_eff == MODE_LATCHED) ? latch_any_nxt : live_any;
  assign det_nxt    = sel_line && !force_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_r   <= MODE_LIVE;
      hold_cnt <= '0;
      detect_o <= 1'b0;
      event_o  <= 1'b0;
    end else begin
      mode_r <= mode_eff;
      if (hold_start) begin
        hold_cnt <= HOLD_LOAD;
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      detect_o <= det_nxt;
      event_o  <= det_nxt && !detect_o;
    end
  end

  assign mode_q = (mode_r == MODE_LATCHED);

endmodule

// File: rtl/pin_sense_detect.sv
module pin_sense_detect #(
  parameter int NUM_PINS    = 8,
  parameter int HOLD_CYCLES = 3,
  parameter int IDX_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_pin,
  input  logic [1:0]          cfg_sense,
  input  logic                mode_we,
  input  logic                mode_val,
  input  logic                clr_we,
  input  logic [NUM_PINS-1:0] clr_mask,
  output logic [NUM_PINS-1:0] latch_o,
  output logic                detect_o,
  output logic                event_o
);

  logic [NUM_PINS-1:0] live_vec;
  logic [NUM_PINS-1:0] latch_nxt;
  logic                clr_fired;
  logic                mode_q;

  psd_sense_cfg #(
    .NUM_PINS (NUM_PINS),
    .IDX_W    (IDX_W)
  ) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .cfg_we    (cfg_we),
    .cfg_pin   (cfg_pin),
    .cfg_sense (cfg_sense),
    .live_vec  (live_vec)
  );

  psd_latch_vec #(
    .NUM_PINS (NUM_PINS)
  ) latch_i (
    .clk       (clk),
    .rst       (rst),
    .live_vec  (live_vec),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask),
    .latch_q   (latch_o),
    .latch_nxt (latch_nxt),
    .clr_fired (clr_fired)
  );

  psd_detect_gen #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) det_i (
    .clk           (clk),
    .rst           (rst),
    .live_any      (|live_vec),
    .latch_any_nxt (|latch_nxt),
    .clr_fired     (clr_fired),
    .mode_we       (mode_we),
    .mode_val      (mode_val),
    .mode_q        (mode_q),
    .detect_o      (detect_o),
    .event_o       (event_o)
  );

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                mode_we,
  input logic                mode_q,
  input logic                clr_we,
  input logic [NUM_PINS-1:0] clr_mask,
  input logic [NUM_PINS-1:0] latch_o,
  input logic                detect_o,
  input logic                event_o
);

  logic [NUM_PINS-1:0] keep_bits;
  assign keep_bits = latch_o & ~(clr_we ? clr_mask : '0);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (latch_o == '0) && !detect_o && !event_o);

  assert_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_o & $past(keep_bits)) == $past(keep_bits)));

  assert_detect_needs_latch_R7: assert property (@(posedge clk) disable iff (rst)
    detect_o |-> (|latch_o));

  assert_event_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(detect_o) |-> event_o);

  assert_event_only_rise_R8: assert property (@(posedge clk) disable iff (rst)
    event_o |-> detect_o && !$past(detect_o));

  assert_event_single_R8: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);

  assert_hold_low_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_we && (|clr_mask) && mode_q && !mode_we) |=> !detect_o);

endmodule

bind pin_sense_detect psd_checker #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .mode_we  (mode_we),
  .mode_q   (mode_q),
  .clr_we   (clr_we),
  .clr_mask (clr_mask),
  .latch_o  (latch_o),
  .detect_o (detect_o),
  .event_o  (event_o)
);

// File: tb/pin_sense_detect_tb_top.sv
`timescale 1ns/1ps
module pin_sense_detect_tb_top;

  localparam int N    = 4;
  localparam int HOLD = 3;
  localparam int IW   = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  pin_in = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_pin = '0;
  logic [1:0]    cfg_sense = '0;
  logic          mode_we = 1'b0;
  logic          mode_val = 1'b0;
  logic          clr_we = 1'b0;
  logic [N-1:0]  clr_mask = '0;
  logic [N-1:0]  latch_o;
  logic          detect_o;
  logic          event_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pin_sense_detect #(.NUM_PINS(N), .HOLD_CYCLES(HOLD)) dut_i (
    .clk (clk), .rst (rst), .pin_in (pin_in),
    .cfg_we (cfg_we), .cfg_pin (cfg_pin), .cfg_sense (cfg_sense),
    .mode_we (mode_we), .mode_val (mode_val),
    .clr_we (clr_we), .clr_mask (clr_mask),
    .latch_o (latch_o), .detect_o (detect_o), .event_o (event_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cfg_we  = 1'b0;
    mode_we = 1'b0;
    clr_we  = 1'b0;
  endtask

  task automatic set_cfg(input int p, input logic [1:0] code);
    cfg_we    = 1'b1;
    cfg_pin   = IW'(p);
    cfg_sense = code;
  endtask

  task automatic do_clr(input logic [N-1:0] m);
    clr_we   = 1'b1;
    clr_mask = m;
  endtask

  task automatic set_mode(input logic v);
    mode_we  = 1'b1;
    mode_val = v;
  endtask

  task automatic chk_state(input string tag, input logic [N-1:0] lat, input logic det, input logic ev);
    chk({tag, " latch"}, 32'(latch_o), 32'(lat));
    chk({tag, " detect"}, 32'(detect_o), 32'(det));
    chk({tag, " event"}, 32'(event_o), 32'(ev));
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    pin_in = '1;
    repeat (3) tick();
    chk_state("R1 in reset", '0, 1'b0, 1'b0);
    rst = 1'b0;
    tick();
    chk_state("R1 after reset, codes disabled", '0, 1'b0, 1'b0);
    pin_in = '0;
    tick();

    // R2 R3 R4 R6 R8 R10: sweep pin x code x starting level
    for (int p = 0; p < N; p++) begin
      for (int c = 0; c < 4; c++) begin
        for (int l = 0; l < 2; l++) begin
          logic [1:0] code;
          logic e1, e2;
          code = 2'(c);
          e1 = code[1] & (1'(l) ^ code[0]);
          e2 = code[1] & ~(1'(l) ^ code[0]);
          pin_in = N'(l) << p;
          set_cfg(p, code);
          tick();
          chk_state("R2 R10 sense applied at write", N'(e1) << p, e1, e1);
          pin_in = N'(1 - l) << p;
          tick();
          chk_state("R3 R6 R8 level flipped", N'(e1 | e2) << p, e2, e2 & ~e1);
          pin_in = '0;
          set_cfg(p, 2'b00);
          do_clr('1);
          tick();
          chk_state("R4 full clear", '0, 1'b0, 1'b0);
        end
      end
    end

    // R5 R11 in live mode
    pin_in = 4'b0001; set_cfg(0, 2'b10); tick();
    chk_state("R6 pin0 high", 4'b0001, 1'b1, 1'b1);
    pin_in = 4'b0011; set_cfg(1, 2'b10); tick();
    chk_state("R3 pin1 joins", 4'b0011, 1'b1, 1'b0);
    pin_in = 4'b0001; tick();
    chk_state("R3 pin1 sticky", 4'b0011, 1'b1, 1'b0);
    do_clr(4'b0011); tick();
    chk_state("R5 R11 clear blocked for pin0, no hold live", 4'b0001, 1'b1, 1'b0);

    // R7 R9 latched mode
    set_mode(1'b1); tick();
    chk_state("R10 mode latched", 4'b0001, 1'b1, 1'b0);
    pin_in = 4'b0000; tick();
    chk_state("R7 detect from latch", 4'b0001, 1'b1, 1'b0);
    pin_in = 4'b0010; tick();
    pin_in = 4'b0000; tick();
    chk("R3 both latched", 32'(latch_o), 32'h3);
    do_clr(4'b0010); tick();
    chk_state("R9 hold c1", 4'b0001, 1'b0, 1'b0);
    tick();
    chk_state("R9 hold c2", 4'b0001, 1'b0, 1'b0);
    tick();
    chk_state("R9 hold c3", 4'b0001, 1'b0, 1'b0);
    tick();
    chk_state("R9 re-raise", 4'b0001, 1'b1, 1'b1);
    tick();
    chk_state("R8 event one cycle", 4'b0001, 1'b1, 1'b0);
    do_clr(4'b0001); tick();
    chk_state("R4 R7 latch emptied", 4'b0000, 1'b0, 1'b0);
    tick();
    chk_state("R7 stays low", 4'b0000, 1'b0, 1'b0);

    pin_in = 4'b0000; set_cfg(2, 2'b11); tick();
    chk_state("R2 low sense", 4'b0100, 1'b1, 1'b1);
    do_clr(4'b0000); tick();
    chk_state("R11 zero mask no hold", 4'b0100, 1'b1, 1'b0);
    do_clr(4'b0100); tick();
    chk_state("R5 R9 blocked clear holds", 4'b0100, 1'b0, 1'b0);
    tick(); tick();
    chk_state("R9 hold end", 4'b0100, 1'b0, 1'b0);
    tick();
    chk_state("R9 re-raise after blocked clear", 4'b0100, 1'b1, 1'b1);

    set_mode(1'b0); tick();
    chk_state("R10 back to live", 4'b0100, 1'b1, 1'b0);
    set_cfg(2, 2'b00); tick();
    chk_state("R6 R10 disable drops live", 4'b0100, 1'b0, 1'b0);
    set_mode(1'b1); tick();
    chk_state("R10 mode write raises event", 4'b0100, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule